// File: doc/BRIEF.md
# DMA channel transfer engine

This block is a single DMA channel. Software programs a source address, a destination address, a count of transfer units and a command word through a small register port, then sets the enable bit in the status/control register. The channel then moves data one unit at a time. For each unit it issues a read request at the source address, keeps the returned data, and issues a write request carrying that data at the destination address. After the write is accepted, the remaining count drops by one. Each address whose increment bit is set then advances by the unit size in bytes.

The unit size (1, 2, 4, 16 or 32 bytes) comes from a three-bit command field. It sets the address step and is presented to the memory side as a size code. When the count reaches zero, the channel records completion, clears its own enable bit and, if allowed by the command word, raises its interrupt line. An unknown unit code or an address that is not aligned to the unit size stops the channel with an address-error flag before any request goes out. The completion, count-terminated and address-error flags stay set until software writes zero to them.

Top module: `dmach_top`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req` is low.
- R2: Register offsets are source 0x00, destination 0x04, count 0x08, status/control 0x10 and command 0x14. Source, destination and command read back as written, and the count reads back in its low CNT_W bits. Offsets 0x0C and 0x18 always read zero.
- R3: A transfer is started only while status bit 0 (enable) is 1 and status bit 2 (halt) is 0. Each unit is a read at the source address (`mem_we`=0) followed by a write at the destination address (`mem_we`=1) carrying the data the read returned.
- R4: Command bits 10:8 select the unit: code 0 = 4 B, 1 = 1 B, 2 = 2 B, 3 = 16 B, 4 = 32 B. `mem_size` carries the byte shift (2, 0, 1, 4, 5), and only the low 8·bytes bits of `mem_wdata` are meaningful.
- R5: After each accepted write, the count decreases by one. The source address advances by the unit size when command bit 23 is 1, and the destination address does the same when command bit 22 is 1. Otherwise an address stays unchanged.
- R6: When the channel runs with a count of zero, it sets status bit 3 (done) and bit 1 (count-terminated) and clears bit 0 (enable). This also applies when the count was zero at enable time, in which case no request is issued.
- R7: `irq` is high exactly while status bit 3 is 1 and command bit 1 is 1.
- R8: A unit code above 4, or a source or destination address not aligned to the unit size, sets status bit 4 (address-error) and bit 2 (halt). No request is issued and the count is left unchanged.
- R9: Status bits 1, 3 and 4 are sticky: a status write of 0 clears them and a write of 1 leaves them as they are without setting them. Bits 0, 2 and 31 take the written value, and the other bits read zero.
- R10: A request that has started is held with stable address and direction until `mem_gnt`. Clearing enable during a unit lets that unit finish and then starts no further unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Request byte address |
| mem_size | output | 3 | Unit byte shift of the request |
| mem_wdata | output | 256 | Write data, unit right-aligned |
| mem_gnt | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 256 | Read data, unit right-aligned |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
The assertions assume the memory side eventually grants every request. They also assume software does not rewrite the source, destination, count or command registers while a unit is in flight. A count write in the same cycle as an accepted write request is excluded from the count-step property. The stimulus keeps within these assumptions: it programs those registers only while the channel is stopped, and it polls the status register before reprogramming. The only write made during a transfer is a status write that clears enable, which the design allows at any time.

// File: rtl/dmach_pkg.sv
// Shared constants and types of the DMA channel engine.
// Assumes 32-bit registers and at most 32-byte transfer units.
package dmach_pkg;
    localparam int REG_AW         = 5;
    localparam int MAX_UNIT_SHIFT = 5;
    localparam int DATA_W         = 8 << MAX_UNIT_SHIFT;

    localparam logic [REG_AW-1:0] OFS_SRC  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_DST  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_CNT  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_STAT = 5'h10;
    localparam logic [REG_AW-1:0] OFS_CMD  = 5'h14;

    localparam int ST_EN    = 0;
    localparam int ST_CTERM = 1;
    localparam int ST_HALT  = 2;
    localparam int ST_DONE  = 3;
    localparam int ST_AERR  = 4;
    localparam int ST_NODSC = 31;

    localparam int CM_SRC_INC = 23;
    localparam int CM_DST_INC = 22;
    localparam int CM_UNIT_LO = 8;
    localparam int CM_IRQ_EN  = 1;

    typedef enum logic [1:0] {XS_IDLE, XS_READ, XS_WRITE} xfer_state_e;

    typedef struct packed {
        logic step;    // one unit written
        logic finish;  // count exhausted while running
        logic fault;   // bad unit code or misaligned address
    } hw_event_t;
endpackage

// File: rtl/dmach_unit_dec.sv
// Decodes the command unit-size code into a byte shift.
// Assumes codes 0..4 are the only legal ones; others flag unit_ok low.
module dmach_unit_dec (
    input  logic [2:0] unit_code,
    output logic [2:0] unit_shift,
    output logic       unit_ok
);
    // Map the code to its shift and legality.
    always_comb begin
        unit_ok    = 1'b1;
        unit_shift = 3'd0;
        case (unit_code)
            3'd0:    unit_shift = 3'd2;
            3'd1:    unit_shift = 3'd0;
            3'd2:    unit_shift = 3'd1;
            3'd3:    unit_shift = 3'd4;
            3'd4:    unit_shift = 3'd5;
            default: unit_ok    = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmach_xfer_fsm.sv
// Sequences one unit as a read then a write, and reports step, finish
// and fault events to the register file. Assumes the addresses and unit
// code stay stable while a unit is in flight.
module dmach_xfer_fsm
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              unit_ok,
    input  logic [2:0]        unit_shift,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              cnt_zero,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    output hw_event_t         ev
);
    xfer_state_e       state_q;
    logic [DATA_W-1:0] hold_q;
    logic [ADDR_W-1:0] lsb_mask;
    logic              misaligned;
    logic              start_ok;

    assign lsb_mask   = ADDR_W'((32'd1 << unit_shift) - 32'd1);
    assign misaligned = |(src_addr & lsb_mask) || |(dst_addr & lsb_mask);
    assign start_ok   = (state_q == XS_IDLE) && run && unit_ok && !misaligned;

    // Advance the unit sequence and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            hold_q  <= '0;
        end else begin
            case (state_q)
                XS_IDLE:  if (start_ok && !cnt_zero) state_q <= XS_READ;
                XS_READ:  if (mem_gnt) begin
                              hold_q  <= mem_rdata;
                              state_q <= XS_WRITE;
                          end
                XS_WRITE: if (mem_gnt) state_q <= XS_IDLE;
                default:  state_q <= XS_IDLE;
            endcase
        end
    end

    // Report events for the register file.
    always_comb begin
        ev.step   = (state_q == XS_WRITE) && mem_gnt;
        ev.finish = start_ok && cnt_zero;
        ev.fault  = (state_q == XS_IDLE) && run && (!unit_ok || misaligned);
    end

    // Drive the memory request from the current state.
    always_comb begin
        mem_req   = (state_q != XS_IDLE);
        mem_we    = (state_q == XS_WRITE);
        mem_addr  = (state_q == XS_WRITE) ? dst_addr : src_addr;
        mem_size  = unit_shift;
        mem_wdata = hold_q;
    end
endmodule

// File: rtl/dmach_regfile.sv
// Holds the channel registers, applies software writes and hardware
// events, and serves reads. Software writes to an address or the count
// take precedence over a hardware step in the same cycle; hardware set
// events on status take precedence over a software write.
module dmach_regfile
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  hw_event_t         ev,
    input  logic [2:0]        unit_shift,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  count,
    output logic [31:0]       cmd,
    output logic              st_en,
    output logic              st_halt,
    output logic              st_done,
    output logic              st_cterm,
    output logic              st_aerr,
    output logic              run,
    output logic              irq
);
    localparam int NPTR = 2;

    logic [ADDR_W-1:0] ptr_val [NPTR];
    logic [ADDR_W-1:0] step_bytes;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       cmd_q;
    logic              en_q, halt_q, done_q, cterm_q, aerr_q, nodsc_q;
    logic              wr_stat;

    assign step_bytes = ADDR_W'(1) << unit_shift;
    assign wr_stat    = reg_we && (reg_addr == OFS_STAT);

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        localparam logic [REG_AW-1:0] MY_OFS = (g == 0) ? OFS_SRC : OFS_DST;
        localparam int                MY_INC = (g == 0) ? CM_SRC_INC : CM_DST_INC;
        logic [ADDR_W-1:0] ptr_q;
        // Load the pointer from software or step it after a unit.
        always_ff @(posedge clk) begin
            if (!rst_n)                                ptr_q <= '0;
            else if (reg_we && reg_addr == MY_OFS)     ptr_q <= reg_wdata[ADDR_W-1:0];
            else if (ev.step && cmd_q[MY_INC])         ptr_q <= ptr_q + step_bytes;
        end
        assign ptr_val[g] = ptr_q;
    end

    // Load the count from software or decrement it after a unit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cnt_q <= '0;
        else if (reg_we && reg_addr == OFS_CNT)    cnt_q <= reg_wdata[CNT_W-1:0];
        else if (ev.step)                          cnt_q <= cnt_q - CNT_W'(1);
    end

    // Store the command word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cmd_q <= '0;
        else if (reg_we && reg_addr == OFS_CMD)    cmd_q <= reg_wdata;
    end

    // Update status: software write first, hardware events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            halt_q  <= 1'b0;
            done_q  <= 1'b0;
            cterm_q <= 1'b0;
            aerr_q  <= 1'b0;
            nodsc_q <= 1'b0;
        end else begin
            if (wr_stat) begin
                en_q    <= reg_wdata[ST_EN];
                halt_q  <= reg_wdata[ST_HALT];
                nodsc_q <= reg_wdata[ST_NODSC];
                cterm_q <= cterm_q & reg_wdata[ST_CTERM];
                done_q  <= done_q  & reg_wdata[ST_DONE];
                aerr_q  <= aerr_q  & reg_wdata[ST_AERR];
            end
            if (ev.finish) begin
                done_q  <= 1'b1;
                cterm_q <= 1'b1;
                en_q    <= 1'b0;
            end
            if (ev.fault) begin
                aerr_q  <= 1'b1;
                halt_q  <= 1'b1;
            end
        end
    end

    // Select the register addressed by the read port.
    always_comb begin
        case (reg_addr)
            OFS_SRC:  reg_rdata = 32'(ptr_val[0]);
            OFS_DST:  reg_rdata = 32'(ptr_val[1]);
            OFS_CNT:  reg_rdata = 32'(cnt_q);
            OFS_STAT: reg_rdata = {nodsc_q, 26'd0, aerr_q, done_q, halt_q, cterm_q, en_q};
            OFS_CMD:  reg_rdata = cmd_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign src_addr = ptr_val[0];
    assign dst_addr = ptr_val[1];
    assign count    = cnt_q;
    assign cmd      = cmd_q;
    assign st_en    = en_q;
    assign st_halt  = halt_q;
    assign st_done  = done_q;
    assign st_cterm = cterm_q;
    assign st_aerr  = aerr_q;
    assign run      = en_q & ~halt_q;
    assign irq      = done_q & cmd_q[CM_IRQ_EN];
endmodule

// File: rtl/dmach_top.sv
// Single DMA channel: register file, unit decoder and transfer sequencer.
// Assumes a memory side that accepts one request per grant and returns
// read data in the grant cycle.
module dmach_top
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq
);
    hw_event_t         ev;
    logic [2:0]        unit_shift;
    logic              unit_ok;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       cmd;
    logic              st_en, st_halt, st_done, st_cterm, st_aerr, run;

    dmach_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev(ev), .unit_shift(unit_shift),
        .src_addr(src_addr), .dst_addr(dst_addr), .count(cnt_q), .cmd(cmd),
        .st_en(st_en), .st_halt(st_halt), .st_done(st_done), .st_cterm(st_cterm),
        .st_aerr(st_aerr), .run(run), .irq(irq)
    );

    dmach_unit_dec dec_i (
        .unit_code(cmd[CM_UNIT_LO +: 3]), .unit_shift(unit_shift), .unit_ok(unit_ok)
    );

    dmach_xfer_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .run(run), .unit_ok(unit_ok), .unit_shift(unit_shift),
        .src_addr(src_addr), .dst_addr(dst_addr), .cnt_zero(cnt_q == '0),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .ev(ev)
    );
endmodule

// File: rtl/dmach_chk.sv
// Assertion checker for dmach_top, attached by bind. Assumes software
// does not rewrite transfer registers while a unit is in flight.
module dmach_chk
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [4:0]        reg_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              st_en,
    input logic              st_halt,
    input logic              st_done,
    input logic              st_cterm,
    input logic              st_aerr
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

    AST_STOPPED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_en && !st_halt) && !mem_req |=> !mem_req); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_gnt && !(reg_we && reg_addr == OFS_CNT)
        |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R5

    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_done) |-> !st_en && st_cterm); // R6

    AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_aerr) |-> st_halt && !mem_req); // R8
endmodule

bind dmach_top dmach_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .cnt_q(cnt_q), .st_en(st_en), .st_halt(st_halt), .st_done(st_done),
    .st_cterm(st_cterm), .st_aerr(st_aerr)
);

// File: tb/dmach_top_tb_top.sv
module dmach_top_tb_top;
    import dmach_pkg::*;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int LOG_N  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [4:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mem_req, mem_we, irq;
    logic [ADDR_W-1:0] mem_addr;
    logic [2:0]        mem_size;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              mem_gnt = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int stall_mode = 0;
    int log_n = 0;
    logic [31:0]       log_addr [LOG_N];
    logic              log_we   [LOG_N];
    logic [2:0]        log_size [LOG_N];
    logic [DATA_W-1:0] log_data [LOG_N];

    always #10 clk = ~clk;

    dmach_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
    );

    function automatic logic [DATA_W-1:0] pat(input logic [31:0] a);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < DATA_W / 32; i++) v[i*32 +: 32] = a * 32'h9E3779B1 + 32'(i) * 32'h01030507;
        return v;
    endfunction

    assign mem_rdata = pat(mem_addr);

    // Memory model: choose grant, then log the handshake the next edge takes.
    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_gnt = (stall_mode == 0) ? 1'b1 : (cyc % 3 != 0);
        if (rst_n && mem_req && mem_gnt && log_n < LOG_N) begin
            log_addr[log_n] = mem_addr;
            log_we[log_n]   = mem_we;
            log_size[log_n] = mem_size;
            log_data[log_n] = mem_wdata;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic wait_stop(output logic [31:0] st);
        for (int i = 0; i < 400; i++) begin
            rd(OFS_STAT, st);
            if (st[ST_DONE] || st[ST_AERR]) break;
        end
    endtask

    // One programmed transfer with expected results computed from R3..R8.
    task automatic run_case(input int code, input bit sinc, input bit dinc, input int cnt,
                            input logic [31:0] src, input logic [31:0] dst, input bit ie, input int stall);
        logic [31:0] st, v, ra, wa;
        int shift, bytes;
        bit ok;
        logic [DATA_W-1:0] m;
        ok = 1'b1;
        case (code)
            0: shift = 2; 1: shift = 0; 2: shift = 1; 3: shift = 4; 4: shift = 5;
            default: begin shift = 0; ok = 1'b0; end
        endcase
        bytes = 1 << shift;
        if ((src % bytes) != 0 || (dst % bytes) != 0) ok = 1'b0;
        for (int b = 0; b < DATA_W; b++) m[b] = (b < 8 * bytes);
        log_n = 0;
        stall_mode = stall;
        wr(OFS_SRC, src);
        wr(OFS_DST, dst);
        wr(OFS_CNT, 32'(cnt));
        wr(OFS_CMD, (32'(sinc) << 23) | (32'(dinc) << 22) | (32'(code) << 8) | (32'(ie) << 1));
        wr(OFS_STAT, 32'h8000_0001);
        wait_stop(st);
        if (!ok) begin
            repeat (3) @(negedge clk);
            chk("R8", "status after fault", st, 32'h8000_0015);
            chk("R8", "no request on fault", 64'(log_n), 0);
            rd(OFS_CNT, v);
            chk("R8", "count kept on fault", v, 32'(cnt));
            chk("R7", "irq low on fault", irq, 0);
        end else begin
            chk("R6", "status after finish", st, 32'h8000_000A);
            chk("R3", "request count", 64'(log_n), 64'(2 * cnt));
            for (int k = 0; k < cnt && 2 * k + 1 < LOG_N; k++) begin
                ra = src + (sinc ? 32'(k * bytes) : 32'd0);
                wa = dst + (dinc ? 32'(k * bytes) : 32'd0);
                chk("R3", "read direction", log_we[2*k], 0);
                chk("R5", "read address", log_addr[2*k], ra);
                chk("R3", "write direction", log_we[2*k+1], 1);
                chk("R5", "write address", log_addr[2*k+1], wa);
                chk("R4", "request size", log_size[2*k+1], 64'(shift));
                chk("R3", "write data matches read", (log_data[2*k+1] & m) == (pat(ra) & m), 1);
            end
            rd(OFS_CNT, v);
            chk("R5", "count at end", v, 0);
            rd(OFS_SRC, v);
            chk("R5", "source at end", v, src + (sinc ? 32'(cnt * bytes) : 32'd0));
            rd(OFS_DST, v);
            chk("R5", "destination at end", v, dst + (dinc ? 32'(cnt * bytes) : 32'd0));
            chk("R7", "irq on finish", irq, 64'(ie));
        end
        wr(OFS_STAT, 32'h0);
        rd(OFS_STAT, v);
        chk("R9", "status cleared", v, 0);
        chk("R7", "irq after clear", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int u, n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "mem_req at reset", mem_req, 0);
        chk("R1", "irq at reset", irq, 0);
        for (int a = 0; a < 7; a++) begin
            rd(5'(a * 4), v);
            chk("R1", "register at reset", v, 0);
        end
        // R2: read back and offsets
        wr(OFS_SRC, 32'hDEAD_BEE0); rd(OFS_SRC, v); chk("R2", "source readback", v, 32'hDEAD_BEE0);
        wr(OFS_DST, 32'h1234_5678); rd(OFS_DST, v); chk("R2", "destination readback", v, 32'h1234_5678);
        wr(OFS_CNT, 32'hABCD_0F0F); rd(OFS_CNT, v); chk("R2", "count readback", v, 32'h0000_0F0F);
        wr(OFS_CMD, 32'h00C0_0700); rd(OFS_CMD, v); chk("R2", "command readback", v, 32'h00C0_0700);
        wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, v); chk("R2", "offset 0x0C", v, 0);
        wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, v); chk("R2", "offset 0x18", v, 0);
        wr(OFS_STAT, 32'hFFFF_FFFC); rd(OFS_STAT, v); chk("R9", "status writable bits", v, 32'h8000_0004);
        wr(OFS_STAT, 32'h0);
        chk("R3", "no request while stopped", 64'(log_n), 0);
        // R4 R5 R6 R8: sweep unit codes, increment modes and counts
        for (int code = 0; code < 8; code++)
            for (int inc = 0; inc < 4; inc++)
                for (int c = 0; c < 3; c++)
                    run_case(code, inc[1], inc[0], (c == 2) ? 3 : c, 32'h0000_1000, 32'h0000_2040,
                             (inc + c) % 2 == 0, (code + c) % 2);
        // R8: misalignment per unit size; odd addresses legal for 1-byte units
        run_case(2, 1, 1, 2, 32'h0000_1001, 32'h0000_2000, 1, 0);
        run_case(3, 1, 1, 2, 32'h0000_1000, 32'h0000_2008, 1, 0);
        run_case(4, 1, 0, 1, 32'h0000_1010, 32'h0000_2000, 0, 0);
        run_case(1, 1, 1, 3, 32'h0000_1003, 32'h0000_2005, 1, 1);
        // R3: halt blocks the channel even when enabled
        log_n = 0; stall_mode = 0;
        wr(OFS_SRC, 32'h100); wr(OFS_DST, 32'h200); wr(OFS_CNT, 2); wr(OFS_CMD, 32'h00C0_0002);
        wr(OFS_STAT, 32'h5);
        repeat (20) @(negedge clk);
        chk("R3", "halted channel issues nothing", 64'(log_n), 0);
        rd(OFS_CNT, v); chk("R3", "halted count kept", v, 2);
        wr(OFS_STAT, 32'h1);
        wait_stop(v);
        chk("R3", "resumed after halt cleared", 64'(log_n), 4);
        chk("R6", "status after resume", v, 32'h0000_000A);
        // R9: writing 1 keeps sticky flags; writing 1 does not set them
        wr(OFS_STAT, 32'h0000_000A); rd(OFS_STAT, v); chk("R9", "sticky kept by 1", v, 32'h0000_000A);
        chk("R7", "irq while done", irq, 1);
        wr(OFS_STAT, 32'h0); wr(OFS_STAT, 32'h0000_001A); rd(OFS_STAT, v);
        chk("R9", "sticky not set by 1", v, 0);
        // R10: clear enable during a stalled transfer
        log_n = 0; stall_mode = 1;
        wr(OFS_SRC, 32'h300); wr(OFS_DST, 32'h400); wr(OFS_CNT, 6); wr(OFS_CMD, 32'h00C0_0100);
        wr(OFS_STAT, 32'h1);
        repeat (6) @(negedge clk);
        wr(OFS_STAT, 32'h0);
        repeat (30) @(negedge clk);
        u = 0;
        for (int i = 0; i < log_n; i++) if (log_we[i]) u++;
        chk("R10", "in-flight unit completed", 64'(log_n), 64'(2 * u));
        chk("R10", "stopped early", 64'(u > 0 && u < 6), 1);
        rd(OFS_CNT, v); chk("R10", "count matches units", v, 32'(6 - u));
        rd(OFS_SRC, v); chk("R10", "source matches units", v, 32'h300 + 32'(u));
        rd(OFS_STAT, v); chk("R10", "no completion after disable", v, 0);
        n0 = log_n;
        repeat (10) @(negedge clk);
        chk("R10", "no further requests", 64'(log_n), 64'(n0));
        stall_mode = 0;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule